// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a 16-bit offset into a 20-bit byte address by combining it with one of four 16-bit segment bases. The four bases are code, stack, data and extra. The physical address is the chosen base shifted left by four bits plus the offset, kept to 20 bits, so it wraps back through zero past the top of the 1 MB space. Each access request carries its kind and the base register the offset came from. The block picks the default segment from these two fields. A per-access override, valid only in the cycle of the request, can replace the default for ordinary operand accesses. It acts the way a segment prefix on an instruction would.

Three of the bases (stack, data, extra) are loaded through a plain write port. The code base ignores that port. It changes only when a far-transfer strobe delivers a new value. Results are registered: the address and the index of the chosen segment appear one cycle after the request, together with a valid flag.

Top module: `seg_agu`

## Requirements
- R1: After reset, addr_valid is 0, the code base is FFFFh and the stack, data and extra bases are 0000h.
- R2: A request with req_valid high in cycle N gives addr_valid high in cycle N+1, and addr_valid is low in any cycle that follows a cycle without a request. phys_addr is then ((base << 4) + offset) mod 2^20, using the base values held when the request was sampled.
- R3: acc_kind 0 (instruction fetch) always selects the code segment (seg_idx 1) and ignores the override.
- R4: An operand access (acc_kind 1 or 3) with no override and base_sel 3 (stack pointer) or 4 (base pointer) selects the stack segment (seg_idx 2).
- R5: An operand access with no override and any other base_sel (0 general register, 1 source index, 2 destination index, 5 to 7) selects the data segment (seg_idx 3).
- R6: acc_kind 2 (string destination) always selects the extra segment (seg_idx 0) and ignores the override.
- R7: On an operand access with ovr_valid high, seg_idx equals ovr_seg (0 extra, 1 code, 2 stack, 3 data). The override has no effect on any later request.
- R8: wr_en with wr_sel 0, 2 or 3 loads wr_data into that base. The new value is used by requests from the next cycle on, and a request in the same cycle still sees the old value. wr_en with wr_sel 1 leaves the code base unchanged.
- R9: far_ld loads far_cs into the code base. The code base changes in no other way.
- R10: An address sum above FFFFFh wraps: base FFFFh with offset FFFFh gives 0FFEFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request this cycle |
| acc_kind | input | 2 | 0 fetch, 1 or 3 operand, 2 string destination |
| base_sel | input | 3 | Base register of the offset: 0 general, 1 source index, 2 destination index, 3 stack pointer, 4 base pointer |
| offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Segment override for this request |
| ovr_seg | input | 2 | Override segment index |
| wr_en | input | 1 | Segment base write strobe |
| wr_sel | input | 2 | Segment index to write |
| wr_data | input | 16 | Value to write |
| far_ld | input | 1 | Far-transfer strobe, loads the code base |
| far_cs | input | 16 | New code base for a far transfer |
| addr_valid | output | 1 | phys_addr and seg_idx are valid |
| phys_addr | output | 20 | Physical byte address |
| seg_idx | output | 2 | Segment used: 0 extra, 1 code, 2 stack, 3 data |

## Verification
A wrong segment choice shows up at the next clock edge as a wrong seg_idx and an address off by a multiple of 16. A corrupted or wrongly written base shows up only when a later request selects that segment. The override can pick any of the four segments, so the bench reads every base back at offset 0, where phys_addr[19:4] is the base itself. A stray write or a missed far load is therefore seen on the first request that follows it.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

  // Segment index encoding, shared by override, write port and output
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_t;

  // Access kinds
  localparam logic [1:0] KIND_FETCH  = 2'd0;
  localparam logic [1:0] KIND_OPER   = 2'd1;
  localparam logic [1:0] KIND_STRDST = 2'd2;
  localparam logic [1:0] KIND_OPER2  = 2'd3;

  // Base register codes that default to the stack segment
  localparam logic [2:0] BASE_SP = 3'd3;
  localparam logic [2:0] BASE_BP = 3'd4;

endpackage

// File: rtl/seg_agu_regfile.sv
module seg_agu_regfile #(
  parameter int SEG_W    = 16,
  parameter int NUM_SEG  = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  localparam int SEL_W   = $clog2(NUM_SEG)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [SEG_W-1:0]               wr_data,
  input  logic                           far_ld,
  input  logic [SEG_W-1:0]               far_data,
  output logic [NUM_SEG-1:0][SEG_W-1:0]  seg_vals
);
  import seg_agu_pkg::*;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [SEG_W-1:0] base_q;
    if (g == int'(SEG_CODE)) begin : g_code
      // code base: far-transfer strobe is its only writer
      always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= CODE_RST;
        else if (far_ld) base_q <= far_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                                  base_q <= '0;
        else if (wr_en && wr_sel == SEL_W'(g))       base_q <= wr_data;
      end
    end
    assign seg_vals[g] = base_q;
  end

endmodule

// File: rtl/seg_agu_select.sv
module seg_agu_select (
  input  logic [1:0] acc_kind,
  input  logic [2:0] base_sel,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output logic [1:0] seg_idx,
  output logic       ovr_applied
);
  import seg_agu_pkg::*;

  logic is_oper;
  assign is_oper     = (acc_kind == KIND_OPER) || (acc_kind == KIND_OPER2);
  assign ovr_applied = is_oper && ovr_valid;

  always_comb begin
    unique case (acc_kind)
      KIND_FETCH:  seg_idx = SEG_CODE;
      KIND_STRDST: seg_idx = SEG_EXTRA;
      default: begin
        if (ovr_valid)
          seg_idx = ovr_seg;
        else if (base_sel == BASE_SP || base_sel == BASE_BP)
          seg_idx = SEG_STACK;
        else
          seg_idx = SEG_DATA;
      end
    endcase
  end

endmodule

// File: rtl/seg_agu_addr.sv
module seg_agu_addr #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0] base,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  phys
);

  // shifted base plus zero-extended offset, carry out of the top dropped
  function automatic logic [PA_W-1:0] phys_of(input logic [SEG_W-1:0] b,
                                              input logic [OFF_W-1:0] o);
    logic [PA_W-1:0] shifted;
    logic [PA_W-1:0] ext;
    shifted = {b, {SEG_SHIFT{1'b0}}};
    ext     = PA_W'(o);
    return shifted + ext;
  endfunction

  assign phys = phys_of(base, offset);

endmodule

// File: rtl/seg_agu.sv
module seg_agu #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NUM_SEG   = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  localparam int PA_W     = SEG_W + SEG_SHIFT,
  localparam int SEL_W    = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        acc_kind,
  input  logic [2:0]        base_sel,
  input  logic [OFF_W-1:0]  offset,
  input  logic              ovr_valid,
  input  logic [SEL_W-1:0]  ovr_seg,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              far_ld,
  input  logic [SEG_W-1:0]  far_cs,
  output logic              addr_valid,
  output logic [PA_W-1:0]   phys_addr,
  output logic [SEL_W-1:0]  seg_idx
);
  import seg_agu_pkg::*;

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals;
  logic [SEL_W-1:0]              sel_idx_w;
  logic [SEG_W-1:0]              sel_base_w;
  logic [PA_W-1:0]               pa_w;

  // named internal events for the checker
  logic             ovr_applied_w;
  logic             far_event_w;
  logic [SEG_W-1:0] code_seg_w;

  assign far_event_w = far_ld;
  assign code_seg_w  = seg_vals[SEG_CODE];

  seg_agu_regfile #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .CODE_RST(CODE_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .far_ld(far_ld), .far_data(far_cs),
    .seg_vals(seg_vals)
  );

  seg_agu_select sel_i (
    .acc_kind(acc_kind), .base_sel(base_sel),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .seg_idx(sel_idx_w), .ovr_applied(ovr_applied_w)
  );

  assign sel_base_w = seg_vals[sel_idx_w];

  seg_agu_addr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)
  ) addr_i (
    .base(sel_base_w), .offset(offset), .phys(pa_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      phys_addr  <= '0;
      seg_idx    <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        phys_addr <= pa_w;
        seg_idx   <= sel_idx_w;
      end
    end
  end

endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  acc_kind,
  input logic [2:0]  base_sel,
  input logic [3:0]  offset_lo,
  input logic        ovr_valid,
  input logic [1:0]  ovr_seg,
  input logic [15:0] far_cs,
  input logic        addr_valid,
  input logic [3:0]  phys_lo,
  input logic [1:0]  seg_idx,
  input logic        ovr_applied,
  input logic        far_event,
  input logic [15:0] code_seg
);
  import seg_agu_pkg::*;

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);
  // R2
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> phys_lo == $past(offset_lo));
  // R3
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind == KIND_FETCH) |=> seg_idx == SEG_CODE);
  // R4
  stack_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind[0] && !ovr_valid && (base_sel == BASE_SP || base_sel == BASE_BP))
      |=> seg_idx == SEG_STACK);
  // R6
  strdst_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind == KIND_STRDST) |=> seg_idx == SEG_EXTRA);
  // R7
  override_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ovr_applied) |=> seg_idx == $past(ovr_seg));
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !far_event |=> $stable(code_seg));
  // R9
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_event |=> code_seg == $past(far_cs));

endmodule

bind seg_agu seg_agu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
  .base_sel(base_sel), .offset_lo(offset[3:0]), .ovr_valid(ovr_valid),
  .ovr_seg(ovr_seg), .far_cs(far_cs), .addr_valid(addr_valid),
  .phys_lo(phys_addr[3:0]), .seg_idx(seg_idx), .ovr_applied(ovr_applied_w),
  .far_event(far_event_w), .code_seg(code_seg_w)
);

// File: tb/seg_agu_tb_top.sv
module seg_agu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [2:0]  base_sel = '0;
  logic [15:0] offset = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        far_ld = 1'b0;
  logic [15:0] far_cs = '0;
  logic        addr_valid;
  logic [19:0] phys_addr;
  logic [1:0]  seg_idx;

  int total = 0;
  int fails = 0;
  logic [15:0] model [4];

  always #4 clk = ~clk;

  seg_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .base_sel(base_sel), .offset(offset), .ovr_valid(ovr_valid),
    .ovr_seg(ovr_seg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .far_ld(far_ld), .far_cs(far_cs), .addr_valid(addr_valid),
    .phys_addr(phys_addr), .seg_idx(seg_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_seg(input int k, input int b, input int ov, input int os);
    if (k == 0) return 1;
    if (k == 2) return 0;
    if (ov != 0) return os;
    if (b == 3 || b == 4) return 2;
    return 3;
  endfunction

  function automatic string seg_req(input int k, input int b, input int ov);
    if (k == 0) return "R3";
    if (k == 2) return "R6";
    if (ov != 0) return "R7";
    if (b == 3 || b == 4) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] exp_pa(input logic [15:0] s, input logic [15:0] o);
    int unsigned v;
    v = int'(s) * 16 + int'(o);
    return v % 32'h100000;
  endfunction

  // issue one request at a falling edge, check at the next falling edge
  task automatic access(input int k, input int b, input int ov, input int os,
                        input logic [15:0] off);
    int e;
    e = exp_seg(k, b, ov, os);
    req_valid = 1'b1; acc_kind = 2'(k); base_sel = 3'(b);
    ovr_valid = ov[0]; ovr_seg = 2'(os); offset = off;
    @(negedge clk);
    req_valid = 1'b0; ovr_valid = 1'b0;
    chk("R2 valid", 32'(addr_valid), 32'd1);
    chk(seg_req(k, b, ov), 32'(seg_idx), 32'(e));
    chk("R2 address", 32'(phys_addr), exp_pa(model[e], off));
  endtask

  task automatic seg_write(input int sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel != 1) model[sel] = d;
  endtask

  task automatic far_load(input logic [15:0] d);
    far_ld = 1'b1; far_cs = d;
    @(negedge clk);
    far_ld = 1'b0;
    model[1] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000; model[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 valid low", 32'(addr_valid), 32'd0);
    // R1: read each base back via override at offset 0
    for (int s = 0; s < 4; s++) begin
      access(1, 0, 1, s, 16'h0000);
      chk("R1 reset base", 32'(phys_addr[19:4]), (s == 1) ? 32'hFFFF : 32'h0);
    end
    @(negedge clk);
    chk("R2 valid drops", 32'(addr_valid), 32'd0);

    seg_write(0, 16'hF00F);
    seg_write(2, 16'h1234);
    seg_write(3, 16'hABCD);
    // R8: write port cannot reach the code base
    seg_write(1, 16'h1111);
    access(0, 0, 0, 0, 16'h0000);
    chk("R8 code unchanged", 32'(phys_addr[19:4]), 32'hFFFF);
    // R9: far transfer loads the code base
    far_load(16'h8765);
    access(0, 0, 0, 0, 16'h0010);
    chk("R9 far load", 32'(phys_addr), 32'h87660);

    // near-exhaustive sweep over kind, base, override
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 8; b++)
        for (int ov = 0; ov < 2; ov++)
          for (int os = 0; os < 4; os++)
            access(k, b, ov, os, 16'((k * 64 + b * 8 + ov * 4 + os) * 251 + 16'h0F37));

    // R7: override does not linger into the following request
    access(1, 1, 1, 2, 16'h0004);
    access(1, 1, 0, 0, 16'h0004);
    chk("R7 no linger", 32'(seg_idx), 32'd3);

    // R8: write and request in the same cycle see the old base
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h5555;
    req_valid = 1'b1; acc_kind = 2'd1; base_sel = 3'd0; offset = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R8 same-cycle old", 32'(phys_addr), 32'hABCD0);
    model[3] = 16'h5555;
    access(1, 0, 0, 0, 16'h0000);
    chk("R8 next-cycle new", 32'(phys_addr), 32'h55550);

    // R10: wrap past the top of the address space
    seg_write(3, 16'hFFFF);
    access(1, 0, 0, 0, 16'hFFFF);
    chk("R10 wrap", 32'(phys_addr), 32'h0FFEF);
    seg_write(2, 16'hF001);
    access(1, 3, 0, 0, 16'hFFF0);
    chk("R10 wrap stack", 32'(phys_addr), 32'h00000);

    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule